// File: doc/BRIEF.md
# Two-Bank Interlaced-to-Progressive Frame Buffer Controller

This controller sits between a video decoder that delivers interlaced fields of RGB pixels and a display pipeline that fetches progressive lines. It drives two external frame memories. In any frame, one memory takes writes and the other serves reads. The two memories trade roles once per frame.

The write side runs on the decoder's line-locked pixel clock. It counts pixels and lines and places every field line into every second line slot: odd-field lines go to the even slots and even-field lines to the odd slots, so that the two fields weave into one full frame. The read side runs on the display pixel clock. It turns the display timing's (x, y) position into a linear address, and only positions inside the 640 by 480 active window are fetched. Read data is returned one cycle after the request, taken from the memory that was being read when the request was made.

The write domain decides when to swap banks. Its bank bit crosses into the read domain through a two-flop synchronizer. The read side adopts the bank that is not being written, and it changes its bank only during vertical blank while no request is active.

Top module: `pingpong_fb_ctrl`

## Requirements
- R1: After reset no memory write enable or read enable is asserted and no read data is flagged valid. Writes go to memory 0 (write bank 0) and reads go to memory 1 (read bank 1).
- R2: A pixel with index p (0..719) on line k of an odd field (field input 0) is written at address (2k)·720 + p. This holds for every line, including lines whose slot lies beyond row 479.
- R3: A pixel with index p on line k of an even field (field input 1) is written at address (2k+1)·720 + p.
- R4: After the 720th pixel of a line, the next pixel starts the next line of the field. A line-sync pulse that arrives after a partial line moves to the start of the next line. A line-sync pulse at pixel index 0 has no effect. Frame sync takes priority over line sync, and line sync takes priority over pixel counting.
- R5: The write bank toggles only at a frame-sync pulse that has field input 0 and follows an even field. No other frame-sync pulse toggles it.
- R6: Each valid pixel asserts the write enable of exactly one memory, the one selected by the current write bank. The pixel data appears unchanged on that memory's write data port.
- R7: A read request at x < 640 and y < 480 asserts the read enable of the current read bank's memory only, with address y·720 + x.
- R8: A read request at x ≥ 640 or y ≥ 480 asserts no read enable, and no read data is flagged valid for it.
- R9: One cycle after an in-window request, the output is flagged valid and carries the read data of the memory that was enabled for that request.
- R10: In a cycle with vertical blank high and request low, the read bank becomes the inverse of the synchronized write bank.
- R11: The read bank never changes in a cycle where a read request is active, even during vertical blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side (decoder) pixel clock |
| wrst_n | input | 1 | Write-side synchronous active-low reset |
| w_valid | input | 1 | Active pixel present on w_pix |
| w_pix | input | 24 | RGB pixel to store |
| w_field | input | 1 | Field parity: 0 odd, 1 even (sampled with w_vsync) |
| w_hsync | input | 1 | One-cycle line start pulse |
| w_vsync | input | 1 | One-cycle field start pulse |
| rclk | input | 1 | Read-side (display) pixel clock |
| rrst_n | input | 1 | Read-side synchronous active-low reset |
| r_req | input | 1 | Display requests the pixel at (r_x, r_y) |
| r_x | input | 10 | Display column |
| r_y | input | 10 | Display row |
| r_vblank | input | 1 | Display is in vertical blank |
| r_pix_valid | output | 1 | r_pix carries data for the request of the previous cycle |
| r_pix | output | 24 | Returned RGB pixel |
| m0_we | output | 1 | Memory 0 write enable |
| m0_waddr | output | 20 | Memory 0 write address |
| m0_wdata | output | 24 | Memory 0 write data |
| m1_we | output | 1 | Memory 1 write enable |
| m1_waddr | output | 20 | Memory 1 write address |
| m1_wdata | output | 24 | Memory 1 write data |
| m0_re | output | 1 | Memory 0 read enable |
| m0_raddr | output | 20 | Memory 0 read address |
| m0_rdata | input | 24 | Memory 0 read data, one cycle after m0_re |
| m1_re | output | 1 | Memory 1 read enable |
| m1_raddr | output | 20 | Memory 1 read address |
| m1_rdata | input | 24 | Memory 1 read data, one cycle after m1_re |

## Verification
The assertions rely on a few input conventions:
- Sync inputs are single-cycle pulses, and field parity is meaningful only when frame sync is high.
- The memories return data exactly one read-clock cycle after an enable.
- The write bank stays put for at least three read-clock cycles before the read side samples it in vertical blank.

The stimulus keeps to these conventions. It never puts a pixel in the same cycle as a sync pulse, and it runs the read phases only after the write phases have settled, so the synchronizer output has already caught up with the write bank. The bench memory models answer with a bank tag plus the requested address, so every returned pixel shows which memory served it and from where.

// File: rtl/fb_pkg.sv
// Shared types for the two-bank frame buffer controller.
package fb_pkg;
    // Bank selector: names which of the two external memories is meant.
    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_t;

    // The other bank.
    function automatic bank_t other_bank(input bank_t b);
        return (b == BANK_0) ? BANK_1 : BANK_0;
    endfunction
endpackage

// File: rtl/fb_sync2.sv
// Two-flop level synchronizer for a single slowly changing bit.
// Assumes the source holds its value for several destination cycles.
module fb_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Two-stage capture into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fb_wr_side.sv
// Write-side address generator and bank owner.
// Counts pixels and lines of each interlaced field. Field lines land in
// every second line slot, offset by one slot for the even field. The write
// bank toggles at the start of an odd field that follows an even field.
// Assumes w_hsync and w_vsync are single-cycle pulses. A pixel in a sync
// cycle is written at the pre-sync address.
module fb_wr_side
    import fb_pkg::*;
#(
    parameter int PIX_W    = 24,
    parameter int ADDR_W   = 20,
    parameter int LINE_LEN = 720
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              w_valid,
    input  logic [PIX_W-1:0]  w_pix,
    input  logic              w_field,
    input  logic              w_hsync,
    input  logic              w_vsync,
    output logic [1:0]        we,
    output logic [ADDR_W-1:0] waddr,
    output logic [PIX_W-1:0]  wdata,
    output bank_t             wbank
);
    localparam int CNT_W = $clog2(LINE_LEN);
    localparam logic [ADDR_W-1:0] SLOT   = ADDR_W'(LINE_LEN);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(2 * LINE_LEN);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(LINE_LEN - 1);

    logic [ADDR_W-1:0] line_base;
    logic [CNT_W-1:0]  pix_cnt;
    logic              prev_even;

    // Line slot base, pixel index and bank state; frame sync > line sync > pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_base <= '0;
            pix_cnt   <= '0;
            prev_even <= 1'b0;
            wbank     <= BANK_0;
        end else if (w_vsync) begin
            line_base <= w_field ? SLOT : '0;
            pix_cnt   <= '0;
            prev_even <= w_field;
            if (!w_field && prev_even) begin
                wbank <= other_bank(wbank);
            end
        end else if (w_hsync && pix_cnt != '0) begin
            pix_cnt   <= '0;
            line_base <= line_base + STRIDE;
        end else if (w_valid) begin
            if (pix_cnt == LAST) begin
                pix_cnt   <= '0;
                line_base <= line_base + STRIDE;
            end else begin
                pix_cnt <= pix_cnt + 1'b1;
            end
        end
    end

    // Memory-facing write strobes steered by the current bank.
    always_comb begin
        waddr = line_base + ADDR_W'(pix_cnt);
        wdata = w_pix;
        we[0] = w_valid && (wbank == BANK_0);
        we[1] = w_valid && (wbank == BANK_1);
    end

    // R6
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we) && ((we != 2'b00) == w_valid));

    // R5
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wbank) |-> $past(w_vsync && !w_field));

    // R4
    pix_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(w_valid && !w_vsync && !w_hsync) && $past(pix_cnt) == LAST) |-> pix_cnt == '0);
endmodule

// File: rtl/fb_rd_side.sv
// Read-side address generator, read-bank owner and data return path.
// Converts the display (x, y) into y*LINE_LEN + x, fetching only inside the
// active window. Adopts the bank opposite the synchronized write bank during
// vertical blank, and never while a request is active.
// Assumes the memories answer one cycle after their read enable.
module fb_rd_side
    import fb_pkg::*;
#(
    parameter int PIX_W    = 24,
    parameter int ADDR_W   = 20,
    parameter int LINE_LEN = 720,
    parameter int ACT_W    = 640,
    parameter int ACT_H    = 480,
    parameter int X_W      = 10,
    parameter int Y_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              r_req,
    input  logic [X_W-1:0]    r_x,
    input  logic [Y_W-1:0]    r_y,
    input  logic              r_vblank,
    input  logic              wbank_s,
    input  logic [PIX_W-1:0]  rdata0,
    input  logic [PIX_W-1:0]  rdata1,
    output logic [1:0]        re,
    output logic [ADDR_W-1:0] raddr,
    output logic              r_pix_valid,
    output logic [PIX_W-1:0]  r_pix
);
    bank_t rbank;
    bank_t sel_q;
    logic  hit;

    // Window test and linear address for the requested pixel.
    always_comb begin
        hit   = r_req && (int'(r_x) < ACT_W) && (int'(r_y) < ACT_H);
        raddr = ADDR_W'(r_y) * ADDR_W'(LINE_LEN) + ADDR_W'(r_x);
        re[0] = hit && (rbank == BANK_0);
        re[1] = hit && (rbank == BANK_1);
    end

    // Read bank follows the inverse write bank, only in idle vertical blank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbank <= BANK_1;
        end else if (r_vblank && !r_req) begin
            rbank <= other_bank(bank_t'(wbank_s));
        end
    end

    // Remember which memory answers next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_pix_valid <= 1'b0;
            sel_q       <= BANK_0;
        end else begin
            r_pix_valid <= hit;
            sel_q       <= rbank;
        end
    end

    // Return mux for the memory that was enabled.
    always_comb begin
        r_pix = (sel_q == BANK_1) ? rdata1 : rdata0;
    end

    // R11
    rbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rbank) |-> $past(r_vblank && !r_req));

    // R8
    rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (re != 2'b00) |-> (int'(r_x) < ACT_W && int'(r_y) < ACT_H && r_req));

    // R7
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(re));

    // R9
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_pix_valid |-> $past(re != 2'b00));
endmodule

// File: rtl/pingpong_fb_ctrl.sv
// Top of the two-bank frame buffer controller.
// Writes interlaced fields into one memory while the other is read
// progressively. The write-domain bank bit reaches the read domain through a
// two-flop synchronizer. Assumes the two clocks are unrelated.
module pingpong_fb_ctrl
    import fb_pkg::*;
#(
    parameter int PIX_W    = 24,
    parameter int ADDR_W   = 20,
    parameter int LINE_LEN = 720,
    parameter int ACT_W    = 640,
    parameter int ACT_H    = 480,
    parameter int X_W      = 10,
    parameter int Y_W      = 10
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              w_valid,
    input  logic [PIX_W-1:0]  w_pix,
    input  logic              w_field,
    input  logic              w_hsync,
    input  logic              w_vsync,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              r_req,
    input  logic [X_W-1:0]    r_x,
    input  logic [Y_W-1:0]    r_y,
    input  logic              r_vblank,
    output logic              r_pix_valid,
    output logic [PIX_W-1:0]  r_pix,
    output logic              m0_we,
    output logic [ADDR_W-1:0] m0_waddr,
    output logic [PIX_W-1:0]  m0_wdata,
    output logic              m1_we,
    output logic [ADDR_W-1:0] m1_waddr,
    output logic [PIX_W-1:0]  m1_wdata,
    output logic              m0_re,
    output logic [ADDR_W-1:0] m0_raddr,
    input  logic [PIX_W-1:0]  m0_rdata,
    output logic              m1_re,
    output logic [ADDR_W-1:0] m1_raddr,
    input  logic [PIX_W-1:0]  m1_rdata
);
    logic [1:0]        we;
    logic [1:0]        re;
    logic [ADDR_W-1:0] waddr;
    logic [ADDR_W-1:0] raddr;
    logic [PIX_W-1:0]  wdata;
    bank_t             wbank;
    logic              wbank_s;

    fb_wr_side #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .w_valid(w_valid), .w_pix(w_pix),
        .w_field(w_field), .w_hsync(w_hsync), .w_vsync(w_vsync),
        .we(we), .waddr(waddr), .wdata(wdata), .wbank(wbank)
    );

    fb_sync2 #(.RST_VAL(1'b0)) u_sync (
        .clk(rclk), .rst_n(rrst_n), .d(wbank), .q(wbank_s)
    );

    fb_rd_side #(.PIX_W(PIX_W), .ADDR_W(ADDR_W), .LINE_LEN(LINE_LEN),
                 .ACT_W(ACT_W), .ACT_H(ACT_H), .X_W(X_W), .Y_W(Y_W)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .r_req(r_req), .r_x(r_x), .r_y(r_y),
        .r_vblank(r_vblank), .wbank_s(wbank_s), .rdata0(m0_rdata),
        .rdata1(m1_rdata), .re(re), .raddr(raddr),
        .r_pix_valid(r_pix_valid), .r_pix(r_pix)
    );

    // Fan the shared write and read buses out to both memory ports.
    always_comb begin
        m0_we    = we[0];
        m1_we    = we[1];
        m0_waddr = waddr;
        m1_waddr = waddr;
        m0_wdata = wdata;
        m1_wdata = wdata;
        m0_re    = re[0];
        m1_re    = re[1];
        m0_raddr = raddr;
        m1_raddr = raddr;
    end
endmodule

// File: tb/tb_pingpong_fb_ctrl.sv
module tb_pingpong_fb_ctrl;
    localparam int WCLK_PERIOD = 74;
    localparam int RCLK_PERIOD = 40;
    localparam int LINE = 720;

    logic wclk = 0, rclk = 0;
    logic wrst_n = 0, rrst_n = 0;
    logic w_valid = 0, w_field = 0, w_hsync = 0, w_vsync = 0;
    logic [23:0] w_pix = '0;
    logic r_req = 0, r_vblank = 0;
    logic [9:0] r_x = '0, r_y = '0;
    logic r_pix_valid;
    logic [23:0] r_pix;
    logic m0_we, m1_we, m0_re, m1_re;
    logic [19:0] m0_waddr, m1_waddr, m0_raddr, m1_raddr;
    logic [23:0] m0_wdata, m1_wdata;
    logic [23:0] m0_rdata = '0, m1_rdata = '0;

    int checks = 0, failures = 0;

    // Model state, write side: field parity, line index, pixel index, bank.
    int mf = 0, mk = 0, mp = 0, mwb = 0, mlast_even = 0;
    // Model state, read side.
    int mrb = 1, pend = 0;
    logic [23:0] pend_data;

    always #(WCLK_PERIOD/2) wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    pingpong_fb_ctrl dut (
        .wclk(wclk), .wrst_n(wrst_n), .w_valid(w_valid), .w_pix(w_pix),
        .w_field(w_field), .w_hsync(w_hsync), .w_vsync(w_vsync),
        .rclk(rclk), .rrst_n(rrst_n), .r_req(r_req), .r_x(r_x), .r_y(r_y),
        .r_vblank(r_vblank), .r_pix_valid(r_pix_valid), .r_pix(r_pix),
        .m0_we(m0_we), .m0_waddr(m0_waddr), .m0_wdata(m0_wdata),
        .m1_we(m1_we), .m1_waddr(m1_waddr), .m1_wdata(m1_wdata),
        .m0_re(m0_re), .m0_raddr(m0_raddr), .m0_rdata(m0_rdata),
        .m1_re(m1_re), .m1_raddr(m1_raddr), .m1_rdata(m1_rdata)
    );

    // Memory models: answer with a bank tag and the address one cycle later.
    always @(posedge rclk) begin
        if (m0_re) m0_rdata <= {4'hA, m0_raddr};
        if (m1_re) m1_rdata <= {4'hB, m1_raddr};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One write-clock cycle: drive, compare with the model, then advance the model.
    task automatic wstep(input bit v, input int d, input bit hs, input bit vs,
                         input bit fld, input string req);
        int ea;
        @(negedge wclk);
        w_valid = v; w_pix = d[23:0]; w_hsync = hs; w_vsync = vs; w_field = fld;
        #1;
        ea = (2 * mk + mf) * LINE + mp;
        check(m0_we == (v && mwb == 0) && m1_we == (v && mwb == 1), req, "we{1,0}",
              {m1_we, m0_we}, {v && mwb == 1, v && mwb == 0});
        if (v) begin
            if (mwb == 0)
                check(m0_waddr == ea && m0_wdata == d[23:0], req, "m0 addr", m0_waddr, ea);
            else
                check(m1_waddr == ea && m1_wdata == d[23:0], req, "m1 addr", m1_waddr, ea);
        end
        @(posedge wclk);
        if (vs) begin
            mf = fld; mk = 0; mp = 0;
            if (!fld && mlast_even == 1) mwb = 1 - mwb;
            mlast_even = fld;
        end else if (hs && mp != 0) begin
            mp = 0; mk++;
        end else if (v) begin
            mp++;
            if (mp == LINE) begin mp = 0; mk++; end
        end
    endtask

    // One read-clock cycle: drive, compare with the model, then advance the model.
    task automatic rstep(input bit rq, input int x, input int y, input bit vb,
                         input string req);
        bit hit;
        int ea;
        @(negedge rclk);
        r_req = rq; r_x = x[9:0]; r_y = y[9:0]; r_vblank = vb;
        #1;
        hit = rq && x < 640 && y < 480;
        ea = y * LINE + x;
        check(m0_re == (hit && mrb == 0) && m1_re == (hit && mrb == 1), req, "re{1,0}",
              {m1_re, m0_re}, {hit && mrb == 1, hit && mrb == 0});
        if (hit)
            check((mrb == 0 ? m0_raddr : m1_raddr) == ea, req, "raddr",
                  (mrb == 0 ? m0_raddr : m1_raddr), ea);
        check(r_pix_valid == pend, "R9", "valid", r_pix_valid, pend);
        if (pend) check(r_pix == pend_data, "R9", "r_pix", r_pix, pend_data);
        @(posedge rclk);
        pend = hit;
        pend_data = {(mrb == 0 ? 4'hA : 4'hB), ea[19:0]};
        if (vb && !rq) mrb = 1 - mwb;
    endtask

    initial begin
        #(WCLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge wclk);
        @(negedge wclk); #1;
        // R1: reset state at the ports
        check(!m0_we && !m1_we && !m0_re && !m1_re && !r_pix_valid, "R1", "idle",
              {m0_we, m1_we, m0_re, m1_re, r_pix_valid}, 0);
        wrst_n = 1; rrst_n = 1;

        // R1, R2: first odd field goes to memory 0 from slot 0
        wstep(0, 0, 0, 1, 0, "R5");
        for (int i = 0; i < 3; i++) wstep(1, 24'h100 + i, 0, 0, 0, "R2");
        // R4: partial line then line sync -> next slot
        wstep(0, 0, 1, 0, 0, "R4");
        for (int i = 0; i < LINE; i++) wstep(1, i, 0, 0, 0, "R4");
        // R4: automatic wrap after 720 pixels
        wstep(1, 24'h777, 0, 0, 0, "R4");
        // R3: even field, slot offset by one line
        wstep(0, 0, 0, 1, 1, "R5");
        wstep(0, 0, 1, 0, 0, "R4");   // line sync at pixel 0: no effect
        for (int i = 0; i < 4; i++) wstep(1, 24'h200 + i, 0, 0, 0, "R3");
        wstep(0, 0, 1, 0, 0, "R4");
        wstep(1, 24'h300, 0, 0, 0, "R3");
        // R5: odd field after even -> swap to memory 1
        wstep(0, 0, 0, 1, 0, "R5");
        wstep(1, 24'h400, 0, 0, 0, "R6");
        // R5: odd after odd -> no swap
        wstep(0, 0, 0, 1, 0, "R5");
        // R2: long field, slots beyond row 479 still stored
        for (int k = 0; k < 250; k++) begin
            wstep(1, k, 0, 0, 0, "R2");
            wstep(0, 0, 1, 0, 0, "R4");
        end
        wstep(1, 24'h555, 0, 0, 0, "R2");

        // Read side: bank still the reset value 1
        for (int i = 0; i < 3; i++) rstep(0, 0, 0, 0, "R1");
        rstep(1, 5, 0, 0, "R7");
        rstep(1, 639, 479, 0, "R7");
        rstep(1, 640, 0, 0, "R8");
        rstep(1, 0, 480, 0, "R8");
        // R11: blank with an active request does not move the bank
        rstep(1, 1, 1, 1, "R11");
        rstep(1, 2, 1, 0, "R11");
        // R10: idle blank adopts inverse of write bank (1) -> 0
        rstep(0, 0, 0, 1, "R10");
        rstep(1, 3, 2, 0, "R10");
        rstep(1, 100, 200, 0, "R7");
        rstep(0, 0, 0, 0, "R9");

        // Another frame: even then odd -> write bank back to 0
        wstep(0, 0, 0, 1, 1, "R5");
        wstep(1, 24'h600, 0, 0, 0, "R3");
        wstep(0, 0, 0, 1, 0, "R5");
        wstep(1, 24'h601, 0, 0, 0, "R6");
        wstep(0, 0, 0, 0, 0, "R6");
        for (int i = 0; i < 4; i++) rstep(0, 0, 0, 0, "R10");
        rstep(0, 0, 0, 1, "R10");
        rstep(1, 7, 9, 0, "R10");
        rstep(1, 700, 9, 0, "R8");
        rstep(0, 0, 0, 0, "R9");
        rstep(0, 0, 0, 0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule